// File: doc/BRIEF.md
# Framed Serial Word Shifter

This block converts a parallel word into a serial bit stream for a serial-input digital-to-analog converter. A one-cycle load strobe captures the word. The most significant bit is on the serial output right after the loading edge, with no shift taken first. After that, one bit leaves per clock, most significant first. Once the last bit has gone out, zeros follow until the next load.

A bit counter sets the frame. It returns to zero on every load and advances on every shift cycle. Both framing outputs are registered and decoded from the counter value seen at each clock edge. The active-low chip-select is low while the bits stream out. At the edge where the counter holds its final value, chip-select goes high and a one-cycle end-of-word pulse is raised. A converter can latch the word on that pulse.

The counter keeps running and wraps when no new load arrives. The frame outputs therefore repeat every word-length cycles, and the data during those repeats is all zeros.

Top module: `framedShifterTop`

## Requirements
- R1: While reset (synchronous, active high) is sampled high, the next outputs are: serial output 0, chip-select (active low) 1 and end-of-word 0. Reset also returns the bit counter to 0.
- R2: When load is sampled high without reset, the word is captured. Bit 15 of the word is on the serial output right after that edge, and the bit counter restarts at 0.
- R3: On each edge with neither reset nor load, the register shifts left by one. The serial output then shows bits 14, 13 and so on down to 0 on successive cycles, and the bit counter advances by one.
- R4: Load takes priority over shifting. A load during a transfer discards the remaining bits, presents the new bit 15 and restarts the count at 0.
- R5: At an edge without reset where the bit counter holds 15, chip-select and end-of-word both become 1 for the next cycle. With a load on edge 0 this is edge 16, one cycle after bit 0 is shown.
- R6: At any edge without reset where the counter does not hold 15, the next chip-select and end-of-word are both 0. This includes load edges.
- R7: Without a load, the counter wraps from 15 to 0 and keeps running, so the end-of-word pulse repeats every 16 cycles and always lasts one cycle.
- R8: After bit 0 has been shifted out, the serial output is 0 until the next load.
- R9: Reset overrides a load strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loadStrobe | input | 1 | Captures dataIn on the next edge |
| dataIn | input | 16 | Parallel word to serialize |
| serialOut | output | 1 | Serial bit, most significant first |
| chipSelN | output | 1 | Active-low frame select |
| wordDone | output | 1 | One-cycle end-of-word pulse |

## Verification
The main function is tried with several words. A mixed pattern shows whether bits come out in the right order and whether the first one appears without an extra shift. Patterns with only the top or bottom bit set catch an off-by-one at either end of the word. A reload in the middle of a transfer separates load priority from plain shifting. A long idle run after the last bit shows the zero fill and the wrap-around pulse period. A reset held together with a load shows that reset wins.

// File: rtl/shifterPkg.sv
package shifterPkg;

  // Strobes from control to datapath; exactly one is high per cycle.
  typedef struct packed {
    logic clear;
    logic load;
    logic shift;
  } shiftCmd_t;

endpackage

// File: rtl/shiftCtrl.sv
module shiftCtrl
  import shifterPkg::*;
#(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadStrobe,
  output shiftCmd_t        cmd,
  output logic [CNT_W-1:0] bitCount,
  output logic             chipSelN,
  output logic             wordDone
);

  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WORD_W - 1);

  logic atLast;

  always_comb begin
    cmd.clear = rst;
    cmd.load  = !rst && loadStrobe;
    cmd.shift = !rst && !loadStrobe;
  end

  assign atLast = (bitCount == LAST_POS);

  // Bit position counter
  always_ff @(posedge clk) begin
    if (cmd.clear) begin
      bitCount <= '0;
    end else if (cmd.load) begin
      bitCount <= '0;
    end else if (atLast) begin
      bitCount <= '0;
    end else begin
      bitCount <= bitCount + CNT_W'(1);
    end
  end

  // Frame outputs decoded from the counter value seen at the edge
  always_ff @(posedge clk) begin
    if (rst) begin
      chipSelN <= 1'b1;
      wordDone <= 1'b0;
    end else if (atLast) begin
      chipSelN <= 1'b1;
      wordDone <= 1'b1;
    end else begin
      chipSelN <= 1'b0;
      wordDone <= 1'b0;
    end
  end

endmodule

// File: rtl/shiftDatapath.sv
module shiftDatapath
  import shifterPkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  shiftCmd_t         cmd,
  input  logic [WORD_W-1:0] dataIn,
  output logic [WORD_W-1:0] shiftWord
);

  // Single driver for the shift register
  always_ff @(posedge clk) begin
    if (cmd.clear) begin
      shiftWord <= '0;
    end else if (cmd.load) begin
      shiftWord <= dataIn;
    end else if (cmd.shift) begin
      shiftWord <= {shiftWord[WORD_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/framedShifterTop.sv
module framedShifterTop
  import shifterPkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadStrobe,
  input  logic [WORD_W-1:0] dataIn,
  output logic              serialOut,
  output logic              chipSelN,
  output logic              wordDone
);

  localparam int CNT_W = $clog2(WORD_W);

  shiftCmd_t         cmd;
  logic [CNT_W-1:0]  bitCount;
  logic [WORD_W-1:0] shiftWord;

  shiftCtrl #(.WORD_W(WORD_W)) uCtrl (
    .clk        (clk),
    .rst        (rst),
    .loadStrobe (loadStrobe),
    .cmd        (cmd),
    .bitCount   (bitCount),
    .chipSelN   (chipSelN),
    .wordDone   (wordDone)
  );

  shiftDatapath #(.WORD_W(WORD_W)) uPath (
    .clk       (clk),
    .cmd       (cmd),
    .dataIn    (dataIn),
    .shiftWord (shiftWord)
  );

  assign serialOut = shiftWord[WORD_W-1];

endmodule

// File: rtl/shifterChecker.sv
module shifterChecker #(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              loadStrobe,
  input logic [WORD_W-1:0] dataIn,
  input logic              serialOut,
  input logic              chipSelN,
  input logic              wordDone,
  input logic [CNT_W-1:0]  bitCount,
  input logic [WORD_W-1:0] shiftWord
);

  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WORD_W - 1);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (chipSelN && !wordDone && !serialOut && bitCount == '0)); // R1

  AST_LOAD_MSB: assert property (@(posedge clk) disable iff (rst)
    (loadStrobe && !rst) |=> (serialOut == $past(dataIn[WORD_W-1]) && bitCount == '0)); // R2

  AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (rst)
    (!loadStrobe && !rst) |=> (shiftWord[WORD_W-1:1] == $past(shiftWord[WORD_W-2:0]) && !shiftWord[0])); // R3

  AST_DONE_MEANS_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
    wordDone |-> chipSelN); // R5

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (bitCount == LAST_POS && !rst) |=> (wordDone && chipSelN)); // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wordDone |=> !wordDone); // R7

  AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (bitCount == LAST_POS && !loadStrobe && !rst) |=> bitCount == '0); // R7

endmodule

bind framedShifterTop shifterChecker #(.WORD_W(WORD_W)) uChk (
  .clk        (clk),
  .rst        (rst),
  .loadStrobe (loadStrobe),
  .dataIn     (dataIn),
  .serialOut  (serialOut),
  .chipSelN   (chipSelN),
  .wordDone   (wordDone),
  .bitCount   (bitCount),
  .shiftWord  (shiftWord)
);

// File: tb/tb_framedShifterTop.sv
module tb_framedShifterTop;

  typedef struct {
    string tag;
    logic  serial;
    logic  csN;
    logic  done;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadStrobe = 1'b0;
  logic [15:0] dataIn = '0;
  logic        serialOut, chipSelN, wordDone;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  expItem_t expQ[$];

  // Behavioural model state, built from the requirements
  logic [15:0] mWord = '0;
  logic [3:0]  mCnt  = '0;

  always #5 clk = ~clk;

  framedShifterTop dut (
    .clk        (clk),
    .rst        (rst),
    .loadStrobe (loadStrobe),
    .dataIn     (dataIn),
    .serialOut  (serialOut),
    .chipSelN   (chipSelN),
    .wordDone   (wordDone)
  );

  task automatic step(input logic r, input logic ld, input logic [15:0] d, input string tag);
    expItem_t it;
    @(negedge clk);
    rst = r;
    loadStrobe = ld;
    dataIn = d;
    if (r) begin                       // R1, R9
      it.csN = 1'b1; it.done = 1'b0;
      mWord = '0; mCnt = '0;
    end else begin
      if (mCnt == 4'd15) begin         // R5
        it.csN = 1'b1; it.done = 1'b1;
      end else begin                   // R6
        it.csN = 1'b0; it.done = 1'b0;
      end
      if (ld) begin                    // R2, R4
        mWord = d; mCnt = '0;
      end else begin                   // R3, R7, R8
        mWord = mWord << 1;
        mCnt  = mCnt + 4'd1;
      end
    end
    it.serial = mWord[15];
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compare after each edge, away from the edge
  always begin
    @(posedge clk);
    #2;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      total++;
      if (serialOut !== e.serial || chipSelN !== e.csN || wordDone !== e.done) begin
        bad++;
        $display("FAIL %s: got ser=%b cs=%b done=%b expected ser=%b cs=%b done=%b",
                 e.tag, serialOut, chipSelN, wordDone, e.serial, e.csN, e.done);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic runIdle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 16'h0000, tag);
  endtask

  initial begin
    // R9: reset wins over load in the same cycle; R1 reset state
    step(1'b1, 1'b1, 16'hFFFF, "R9");
    step(1'b1, 1'b0, 16'h0000, "R1");
    // R2/R3/R5/R6: mixed word, full transfer and frame pulse
    step(1'b0, 1'b1, 16'hB3C1, "R2");
    runIdle(15, "R3");
    step(1'b0, 1'b0, 16'h0000, "R5");
    // R8: zero fill afterwards
    runIdle(6, "R8");
    // R2/R3: only MSB set
    step(1'b0, 1'b1, 16'h8000, "R2");
    runIdle(17, "R3");
    // only LSB set, exercises bit 0 timing
    step(1'b0, 1'b1, 16'h0001, "R2");
    runIdle(16, "R5");
    // R4: reload mid-transfer
    step(1'b0, 1'b1, 16'hF0F0, "R2");
    runIdle(6, "R3");
    step(1'b0, 1'b1, 16'h5A5A, "R4");
    runIdle(18, "R6");
    // R7: idle wraps, pulse every 16 cycles
    runIdle(40, "R7");
    // R1: reset in the middle of a transfer
    step(1'b0, 1'b1, 16'hFFFF, "R2");
    runIdle(4, "R3");
    step(1'b1, 1'b0, 16'h0000, "R1");
    runIdle(20, "R7");
    @(negedge clk);
    loadStrobe = 1'b0;
    wait (expQ.size() == 0);
    @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule